// File: doc/BRIEF.md
# Slotted Ring Network Node

This block is one stop on a one-way ring that connects several processing elements. A fixed set of slots circulates around the ring, one slot per node, and every slot moves exactly one node per clock cycle. Each cycle the node takes in the slot handed over by its upstream neighbour and registers one slot towards its downstream neighbour. A slot carries a valid bit, the identifier of the node that owns it, the sender's address, the receiver's address and a payload of several tokens.

The node pulls out any occupied slot addressed to itself and hands the payload and sender address to the local input side. It leaves slots meant for other nodes untouched. It fills an empty slot with the head of its local output queue when access rules allow. The node may always write into its own slot. When the take-over option is built in, it may also write into an empty slot owned by another node, as long as the message's receiver comes before that slot's owner in the ring direction. In that case the slot is free again before its owner needs it. Extraction comes before injection within a cycle, so a slot emptied at this node can be refilled in the same cycle.

Node identity, ring size, token count, token width and the take-over option are elaboration parameters. The downstream node's ring input is wired to this node's ring output.

Top module: `ring_node`

## Requirements
- R1: While synchronous active-low reset is held, the node's outgoing slot is empty and carries slot identifier NODE_ID, and `rx_valid` is low.
- R2: The slot identifier presented on the ring input appears on the ring output one clock cycle later, in every case.
- R3: When the incoming slot's identifier equals NODE_ID, the slot is free (empty, or addressed to this node), and `tx_valid` is high, then `tx_ready` is high in that cycle. On the next cycle the outgoing slot is valid, with source NODE_ID and with the destination and payload taken from the queue.
- R4: An occupied incoming slot whose destination is not NODE_ID leaves one cycle later with valid, source, destination and payload unchanged, and `tx_ready` stays low.
- R5: An occupied incoming slot addressed to NODE_ID raises `rx_valid` on the next cycle, with its source and payload on `rx_src` and `rx_data`. `rx_valid` is low in every cycle after one with no such slot.
- R6: A slot emptied by extraction leaves with valid low and an all-zero payload unless it is refilled in the same cycle. It is refilled only under the rule of R3 or R7.
- R7: With TAKEOVER=1, a free incoming slot owned by another node is granted to a waiting message exactly when hops(tx_dst) < hops(slot identifier). Here hops(x) = ((x - NODE_ID - 1) mod RING_N) + 1, so a message to the node itself counts RING_N hops and never qualifies.
- R8: With TAKEOVER=0, `tx_ready` is never high for a slot whose identifier differs from NODE_ID.
- R9: The payload holds TOKENS tokens, with token i at bits [i*TOKEN_W +: TOKEN_W]. All tokens travel and are delivered intact together under one identifier, source and destination.
- R10: `tx_ready` is never high while `tx_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ring_in_valid | input | 1 | Incoming slot is occupied |
| ring_in_id | input | ADDR_W | Owner identifier of incoming slot |
| ring_in_src | input | ADDR_W | Sender address of incoming slot |
| ring_in_dst | input | ADDR_W | Receiver address of incoming slot |
| ring_in_data | input | DATA_W | Payload of incoming slot (TOKENS*TOKEN_W) |
| ring_out_valid | output | 1 | Outgoing slot is occupied |
| ring_out_id | output | ADDR_W | Owner identifier of outgoing slot |
| ring_out_src | output | ADDR_W | Sender address of outgoing slot |
| ring_out_dst | output | ADDR_W | Receiver address of outgoing slot |
| ring_out_data | output | DATA_W | Payload of outgoing slot |
| tx_valid | input | 1 | Local output queue has a message |
| tx_ready | output | 1 | Message is written into the slot this cycle |
| tx_dst | input | ADDR_W | Receiver address of the queued message |
| tx_data | input | DATA_W | Payload of the queued message |
| rx_valid | output | 1 | A message was delivered to this node |
| rx_src | output | ADDR_W | Sender of the delivered message |
| rx_data | output | DATA_W | Payload of the delivered message |

## Verification
The hardest case to reach is a slot that arrives addressed to this node and is refilled in the same cycle, under both access rules. The rule can be ownership or take-over, and take-over is allowed or refused depending on how the receiver's distance compares with the owner's. The bench drives the ring input directly, so it can place any identifier, receiver and occupancy at the node on demand. Directed steps cover each such combination, including the refused take-over and a message addressed to the node itself. Seeded random steps then mix arbitrary slots with queue activity. Two instances, one with take-over and one without, see the same stimulus, so the two grant rules are compared cycle by cycle.

// File: rtl/ring_node_pkg.sv
// Shared helpers for the slotted ring node.
// Assumes node and slot identifiers lie in 0 .. ring size - 1.
package ring_node_pkg;

    // Hops from node 'here' to node 'there' going downstream; self counts a full loop.
    function automatic int unsigned ring_hops(int unsigned here, int unsigned there,
                                              int unsigned n);
        return ((there + n - here - 1) % n) + 1;
    endfunction

endpackage

// File: rtl/rn_extract.sv
// Extraction stage: detects an occupied slot addressed to this node and
// registers its sender and payload towards the local input side.
// Assumes the receiver always accepts (no back-pressure on delivery).
module rn_extract #(
    parameter int NODE_ID = 0,
    parameter int ADDR_W  = 2,
    parameter int DATA_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [ADDR_W-1:0] in_src,
    input  logic [ADDR_W-1:0] in_dst,
    input  logic [DATA_W-1:0] in_data,
    output logic              hit,
    output logic              slot_free,
    output logic              rx_valid,
    output logic [ADDR_W-1:0] rx_src,
    output logic [DATA_W-1:0] rx_data
);

    localparam logic [ADDR_W-1:0] OWN = ADDR_W'(NODE_ID);

    // Decide whether the slot ends here and whether it is free for reuse.
    always_comb begin
        hit       = in_valid && (in_dst == OWN);
        slot_free = !in_valid || hit;
    end

    // Hold the delivered message for one cycle on the local side.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_valid <= 1'b0;
            rx_src   <= '0;
            rx_data  <= '0;
        end else begin
            rx_valid <= hit;
            if (hit) begin
                rx_src  <= in_src;
                rx_data <= in_data;
            end
        end
    end

    AST_DELIVER_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_dst == OWN) |=> (rx_valid && rx_src == $past(in_src)
                                         && rx_data == $past(in_data))); // R5
    AST_NO_SPURIOUS_RX: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && in_dst == OWN) |=> !rx_valid); // R5

endmodule

// File: rtl/rn_inject.sv
// Access arbiter: grants the local queue the current slot under the
// ownership rule, and optionally under the take-over rule.
// Assumes extraction has already been accounted for in slot_free.
module rn_inject
    import ring_node_pkg::*;
#(
    parameter int NODE_ID  = 0,
    parameter int RING_N   = 4,
    parameter int ADDR_W   = 2,
    parameter bit TAKEOVER = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slot_free,
    input  logic [ADDR_W-1:0] in_id,
    input  logic              tx_valid,
    input  logic [ADDR_W-1:0] tx_dst,
    output logic              grant
);

    localparam logic [ADDR_W-1:0] OWN = ADDR_W'(NODE_ID);

    logic own_slot;
    logic foreign_ok;

    // Ownership test on the arriving slot.
    always_comb own_slot = (in_id == OWN);

    generate
        if (TAKEOVER) begin : g_takeover
            logic closer;
            // Receiver must be reached before the slot's owner.
            always_comb closer = ring_hops(NODE_ID, 32'(tx_dst), RING_N)
                               < ring_hops(NODE_ID, 32'(in_id), RING_N);
            always_comb foreign_ok = !own_slot && closer;

            AST_TAKEOVER_SHORTER: assert property (@(posedge clk) disable iff (!rst_n)
                (grant && in_id != OWN) |->
                (ring_hops(NODE_ID, 32'(tx_dst), RING_N)
                 < ring_hops(NODE_ID, 32'(in_id), RING_N))); // R7
        end else begin : g_owner_only
            always_comb foreign_ok = 1'b0;

            AST_OWNER_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
                grant |-> (in_id == OWN)); // R8
        end
    endgenerate

    // Final grant: queue has a message, slot is free, and a rule allows it.
    always_comb grant = tx_valid && slot_free && (own_slot || foreign_ok);

    AST_OWN_SLOT_GRANTED: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && slot_free && in_id == OWN) |-> grant); // R3
    AST_GRANT_NEEDS_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> slot_free); // R4

endmodule

// File: rtl/rn_slot_reg.sv
// Output slot register: selects injected, emptied or forwarded contents
// and moves the slot one hop per cycle.
// Assumes grant already implies the slot is free.
module rn_slot_reg #(
    parameter int NODE_ID = 0,
    parameter int ADDR_W  = 2,
    parameter int DATA_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [ADDR_W-1:0] in_id,
    input  logic [ADDR_W-1:0] in_src,
    input  logic [ADDR_W-1:0] in_dst,
    input  logic [DATA_W-1:0] in_data,
    input  logic              hit,
    input  logic              grant,
    input  logic [ADDR_W-1:0] tx_dst,
    input  logic [DATA_W-1:0] tx_data,
    output logic              out_valid,
    output logic [ADDR_W-1:0] out_id,
    output logic [ADDR_W-1:0] out_src,
    output logic [ADDR_W-1:0] out_dst,
    output logic [DATA_W-1:0] out_data
);

    localparam logic [ADDR_W-1:0] OWN = ADDR_W'(NODE_ID);

    logic              nx_valid;
    logic [ADDR_W-1:0] nx_src;
    logic [ADDR_W-1:0] nx_dst;
    logic [DATA_W-1:0] nx_data;

    // Choose slot contents: injection over emptying over forwarding.
    always_comb begin
        nx_valid = in_valid;
        nx_src   = in_src;
        nx_dst   = in_dst;
        nx_data  = in_data;
        if (grant) begin
            nx_valid = 1'b1;
            nx_src   = OWN;
            nx_dst   = tx_dst;
            nx_data  = tx_data;
        end else if (hit) begin
            nx_valid = 1'b0;
            nx_src   = '0;
            nx_dst   = '0;
            nx_data  = '0;
        end
    end

    // Advance the slot one node; reset leaves this node's own slot empty.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_id    <= OWN;
            out_src   <= '0;
            out_dst   <= '0;
            out_data  <= '0;
        end else begin
            out_valid <= nx_valid;
            out_id    <= in_id;
            out_src   <= nx_src;
            out_dst   <= nx_dst;
            out_data  <= nx_data;
        end
    end

    AST_ID_ONE_HOP: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (out_id == $past(in_id))); // R2
    AST_FORWARD_UNCHANGED: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_dst != OWN) |=> (out_valid && out_src == $past(in_src)
            && out_dst == $past(in_dst) && out_data == $past(in_data))); // R4
    AST_EMPTIED_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !grant) |=> (!out_valid && out_data == '0)); // R6

endmodule

// File: rtl/ring_node.sv
// One node of a unidirectional slotted ring. Extracts slots addressed to
// it, forwards the rest, and injects local messages into free slots it
// may use. Assumes ring_out of this node feeds ring_in of the next.
module ring_node #(
    parameter int NODE_ID  = 1,
    parameter int RING_N   = 4,
    parameter int TOKENS   = 2,
    parameter int TOKEN_W  = 8,
    parameter bit TAKEOVER = 1'b1,
    localparam int ADDR_W  = (RING_N > 1) ? $clog2(RING_N) : 1,
    localparam int DATA_W  = TOKENS * TOKEN_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ring_in_valid,
    input  logic [ADDR_W-1:0] ring_in_id,
    input  logic [ADDR_W-1:0] ring_in_src,
    input  logic [ADDR_W-1:0] ring_in_dst,
    input  logic [DATA_W-1:0] ring_in_data,
    output logic              ring_out_valid,
    output logic [ADDR_W-1:0] ring_out_id,
    output logic [ADDR_W-1:0] ring_out_src,
    output logic [ADDR_W-1:0] ring_out_dst,
    output logic [DATA_W-1:0] ring_out_data,
    input  logic              tx_valid,
    output logic              tx_ready,
    input  logic [ADDR_W-1:0] tx_dst,
    input  logic [DATA_W-1:0] tx_data,
    output logic              rx_valid,
    output logic [ADDR_W-1:0] rx_src,
    output logic [DATA_W-1:0] rx_data
);

    logic hit;
    logic slot_free;
    logic grant;

    rn_extract #(
        .NODE_ID (NODE_ID),
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W)
    ) u_extract (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (ring_in_valid),
        .in_src    (ring_in_src),
        .in_dst    (ring_in_dst),
        .in_data   (ring_in_data),
        .hit       (hit),
        .slot_free (slot_free),
        .rx_valid  (rx_valid),
        .rx_src    (rx_src),
        .rx_data   (rx_data)
    );

    rn_inject #(
        .NODE_ID  (NODE_ID),
        .RING_N   (RING_N),
        .ADDR_W   (ADDR_W),
        .TAKEOVER (TAKEOVER)
    ) u_inject (
        .clk       (clk),
        .rst_n     (rst_n),
        .slot_free (slot_free),
        .in_id     (ring_in_id),
        .tx_valid  (tx_valid),
        .tx_dst    (tx_dst),
        .grant     (grant)
    );

    rn_slot_reg #(
        .NODE_ID (NODE_ID),
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W)
    ) u_slot (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (ring_in_valid),
        .in_id     (ring_in_id),
        .in_src    (ring_in_src),
        .in_dst    (ring_in_dst),
        .in_data   (ring_in_data),
        .hit       (hit),
        .grant     (grant),
        .tx_dst    (tx_dst),
        .tx_data   (tx_data),
        .out_valid (ring_out_valid),
        .out_id    (ring_out_id),
        .out_src   (ring_out_src),
        .out_dst   (ring_out_dst),
        .out_data  (ring_out_data)
    );

    // Queue handshake: the message is taken exactly when a slot is granted.
    always_comb tx_ready = grant;

    AST_READY_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready |-> tx_valid); // R10
    AST_INJECT_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready) |=> (ring_out_valid
            && ring_out_src == ADDR_W'(NODE_ID) && ring_out_dst == $past(tx_dst)
            && ring_out_data == $past(tx_data))); // R3
    AST_RESET_EMPTY: assert property (@(posedge clk)
        !rst_n |=> (!ring_out_valid && !rx_valid
                    && ring_out_id == ADDR_W'(NODE_ID))); // R1

endmodule

// File: tb/ring_node_test.sv
`timescale 1ns/1ps
module ring_node_test;

    localparam int ID  = 1;
    localparam int N   = 4;
    localparam int TK  = 2;
    localparam int TW  = 8;
    localparam int AW  = 2;
    localparam int DW  = TK * TW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic          i_v;
    logic [AW-1:0] i_id, i_src, i_dst;
    logic [DW-1:0] i_data;
    logic          t_v;
    logic [AW-1:0] t_dst;
    logic [DW-1:0] t_data;

    logic          a_ov, b_ov, a_rdy, b_rdy, a_rv, b_rv;
    logic [AW-1:0] a_oid, a_osrc, a_odst, b_oid, b_osrc, b_odst, a_rsrc, b_rsrc;
    logic [DW-1:0] a_odata, b_odata, a_rdata, b_rdata;

    int n_chk = 0;
    int n_bad = 0;

    ring_node #(.NODE_ID(ID), .RING_N(N), .TOKENS(TK), .TOKEN_W(TW), .TAKEOVER(1'b1)) uut (
        .clk(clk), .rst_n(rst_n),
        .ring_in_valid(i_v), .ring_in_id(i_id), .ring_in_src(i_src),
        .ring_in_dst(i_dst), .ring_in_data(i_data),
        .ring_out_valid(a_ov), .ring_out_id(a_oid), .ring_out_src(a_osrc),
        .ring_out_dst(a_odst), .ring_out_data(a_odata),
        .tx_valid(t_v), .tx_ready(a_rdy), .tx_dst(t_dst), .tx_data(t_data),
        .rx_valid(a_rv), .rx_src(a_rsrc), .rx_data(a_rdata));

    ring_node #(.NODE_ID(ID), .RING_N(N), .TOKENS(TK), .TOKEN_W(TW), .TAKEOVER(1'b0)) uut_plain (
        .clk(clk), .rst_n(rst_n),
        .ring_in_valid(i_v), .ring_in_id(i_id), .ring_in_src(i_src),
        .ring_in_dst(i_dst), .ring_in_data(i_data),
        .ring_out_valid(b_ov), .ring_out_id(b_oid), .ring_out_src(b_osrc),
        .ring_out_dst(b_odst), .ring_out_data(b_odata),
        .tx_valid(t_v), .tx_ready(b_rdy), .tx_dst(t_dst), .tx_data(t_data),
        .rx_valid(b_rv), .rx_src(b_rsrc), .rx_data(b_rdata));

    task automatic chk(string req, string what, longint act, longint exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Hop count downstream from this node, found by walking the ring.
    function automatic int hops(int t);
        for (int h = 1; h <= N; h++)
            if ((ID + h) % N == t) return h;
        return N;
    endfunction

    function automatic bit exp_grant(bit tk);
        bit hit = i_v && (int'(i_dst) == ID);
        bit fr  = !i_v || hit;
        if (!t_v || !fr) return 1'b0;
        if (int'(i_id) == ID) return 1'b1;
        return tk && (hops(int'(t_dst)) < hops(int'(i_id)));
    endfunction

    function automatic string grant_req(bit tk);
        if (!t_v) return "R10";
        if (i_v && int'(i_dst) != ID) return "R4";
        if (int'(i_id) == ID) return "R3";
        return tk ? "R7" : "R8";
    endfunction

    // Drive one slot and queue state, then check the handshake and next-cycle outputs.
    task automatic step(bit v, int id, int src, int dst, logic [DW-1:0] d,
                        bit tv, int tdst, logic [DW-1:0] td);
        bit ga, gb, hit;
        @(negedge clk);
        i_v = v; i_id = AW'(id); i_src = AW'(src); i_dst = AW'(dst); i_data = d;
        t_v = tv; t_dst = AW'(tdst); t_data = td;
        #1;
        ga = exp_grant(1'b1);
        gb = exp_grant(1'b0);
        hit = v && (dst == ID);
        chk(grant_req(1'b1), "tx_ready takeover", a_rdy, ga);
        chk(grant_req(1'b0), "tx_ready plain", b_rdy, gb);
        @(posedge clk);
        #1;
        for (int k = 0; k < 2; k++) begin
            bit g = (k == 0) ? ga : gb;
            logic ov = (k == 0) ? a_ov : b_ov;
            logic [AW-1:0] oid = (k == 0) ? a_oid : b_oid;
            logic [AW-1:0] osrc = (k == 0) ? a_osrc : b_osrc;
            logic [AW-1:0] odst = (k == 0) ? a_odst : b_odst;
            logic [DW-1:0] od = (k == 0) ? a_odata : b_odata;
            logic rv = (k == 0) ? a_rv : b_rv;
            logic [AW-1:0] rs = (k == 0) ? a_rsrc : b_rsrc;
            logic [DW-1:0] rd = (k == 0) ? a_rdata : b_rdata;
            chk("R2", "out id", oid, id);
            if (g) begin
                chk("R3", "out valid", ov, 1);
                chk("R3", "out src", osrc, ID);
                chk("R3", "out dst", odst, tdst);
                chk("R9", "out data", od, td);
            end else if (hit) begin
                chk("R6", "emptied valid", ov, 0);
                chk("R6", "emptied data", od, 0);
            end else begin
                chk("R4", "fwd valid", ov, v);
                if (v) begin
                    chk("R4", "fwd src", osrc, src);
                    chk("R4", "fwd dst", odst, dst);
                    chk("R9", "fwd data", od, d);
                end
            end
            chk("R5", "rx_valid", rv, hit);
            if (hit) begin
                chk("R5", "rx_src", rs, src);
                chk("R9", "rx_data", rd, d);
            end
        end
    endtask

    initial begin : watchdog
        #(5.0 * 200000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd7421));
        i_v = 0; i_id = '0; i_src = '0; i_dst = '0; i_data = '0;
        t_v = 0; t_dst = '0; t_data = '0;
        repeat (3) @(posedge clk);
        #1;
        chk("R1", "reset out valid", a_ov, 0);
        chk("R1", "reset out id", a_oid, ID);
        chk("R1", "reset rx_valid", a_rv, 0);
        chk("R1", "reset plain out id", b_oid, ID);
        @(negedge clk);
        rst_n = 1'b1;

        // Own empty slot: both variants inject (R3).
        step(0, 1, 0, 0, '0, 1, 3, 16'hA55A);
        // Foreign traffic passes, queue waits (R4).
        step(1, 2, 0, 3, 16'h1234, 1, 3, 16'hBEEF);
        // Own slot delivered here and reused at once (R6, R3).
        step(1, 1, 2, 1, 16'hC0DE, 1, 0, 16'h0F0F);
        // Foreign slot delivered here, receiver closer than owner: take-over (R7, R8).
        step(1, 3, 0, 1, 16'h7E81, 1, 2, 16'h4242);
        // Receiver farther than owner: take-over refused (R7).
        step(0, 2, 0, 0, '0, 1, 3, 16'h9999);
        // Owner far away: take-over allowed (R7).
        step(0, 0, 0, 0, '0, 1, 2, 16'h1357);
        // Message to itself never qualifies for take-over (R7).
        step(0, 0, 0, 0, '0, 1, 1, 16'h2468);
        // Message to itself through the own slot is allowed (R3).
        step(0, 1, 0, 0, '0, 1, 1, 16'hFFFF);
        // Delivery with no queue activity, token boundaries distinct (R5, R9).
        step(1, 0, 3, 1, 16'h80_01, 0, 2, 16'h0000);
        // Empty foreign slot, nothing queued (R10).
        step(0, 3, 0, 0, '0, 0, 2, 16'h5555);

        for (int n = 0; n < 400; n++) begin
            step($urandom_range(0, 1), $urandom_range(0, N - 1), $urandom_range(0, N - 1),
                 $urandom_range(0, N - 1), DW'($urandom),
                 $urandom_range(0, 3) != 0, $urandom_range(0, N - 1), DW'($urandom));
        end

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule